// File: doc/BRIEF.md
# Complete-Folding Current-Source Sequencer

This block turns the measured strengths of fifteen nominally equal unit current sources into a four-bit binary-weighted array. Each source's magnitude is first written into a local bank through a simple load port. A start pulse then runs three rounds of folding. In each round the current elements are put in ascending order of magnitude, the weakest is joined to the strongest, the second weakest to the second strongest, and so on. Each joined pair becomes one element whose magnitude is the sum of the two. The element left in the middle, which has no partner, is frozen as the next binary weight.

The first round freezes a single source as the weight-1 group. The second round freezes a pair of sources as the weight-2 group. The third round freezes a group of four sources as the weight-4 group and sends the last group of eight to the weight-8 position. Because strong and weak sources are combined, random mismatch tends to average out within each group. The result is a table that gives a 2-bit group code for every physical source, plus a done flag. Downstream switching logic uses this table to route each binary input bit to its group. Measuring the sources and switching them are both done outside this block.

Top module: `cf_fold_sequencer`

## Requirements
- R1: After synchronous reset, `done` is 0 and every 2-bit field of `grp_code` is 0.
- R2: A cycle with `load_en` high writes `load_mag` into bank entry `load_idx` when `load_idx` is 0 to 14. An index of 15 writes nothing. An accepted start copies the bank, so later loads affect only the next run.
- R3: Each round orders the live elements by ascending magnitude. When two magnitudes are equal, the element whose lowest member source index is smaller goes first. A merged element takes the smaller of its two lowest indices.
- R4: With m live elements in sorted positions 0..m-1, position j is merged with position m-1-j for every j < (m-1)/2. The merged magnitude is the exact sum of the two magnitudes.
- R5: In round f (f = 0, 1, 2), the element at sorted position (m-1)/2 is unpaired, and each of its sources is given code f. Code 0 means weight 1, code 1 means weight 2, and code 2 means weight 4.
- R6: After the last round, every source of the single remaining element is given code 3, which means weight 8.
- R7: When a run finishes, exactly 1, 2, 4 and 8 sources hold codes 0, 1, 2 and 3 respectively. Each source's code sits in `grp_code[2*s+1:2*s]`.
- R8: `done` rises exactly 48 clock edges after the edge that accepts start. It then stays high, with the table unchanged, until the next accepted start. That start clears `done` at its own edge.
- R9: A start that arrives while a run is in progress is ignored. The run's timing and result do not change.
- R10: Sums never lose a carry. Even when every magnitude is the 12-bit maximum, the eight-source group sum is kept exactly in the 15-bit accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write strobe for the magnitude bank |
| load_idx | input | 4 | Bank entry to write (0 to 14) |
| load_mag | input | 12 | Measured magnitude, unsigned |
| start | input | 1 | Begin a folding run; accepted only when idle or done |
| done | output | 1 | Table valid; held until the next accepted start |
| grp_code | output | 30 | 2-bit group code per source, with source s at bits 2s+1:2s |

## Verification
The assertions assume that reset is applied before the first start. The group-size and done-timing properties also assume that each run is allowed to complete between accepted starts, which holds because start is ignored while the sequencer is busy. The bench drives the block only through the load and start ports, with one-cycle start pulses. It deliberately pulses start and writes the bank in the middle of a run, so the ignored-start and bank-copy rules are exercised rather than avoided. The magnitudes stay within 12 bits because of the port width, and the all-maximum pattern covers the widest sums.

// File: rtl/cf_pkg.sv
package cf_pkg;

    parameter int NBITS = 4;
    parameter int MAGW  = 12;

    localparam int NSRC     = (1 << NBITS) - 1;
    localparam int ACCW     = MAGW + NBITS - 1;
    localparam int IDXW     = $clog2(NSRC + 1);
    localparam int CODEW    = $clog2(NBITS);
    localparam int LASTFOLD = NBITS - 2;
    localparam int NPAIR    = (NSRC - 1) / 2;

    // One live element: summed magnitude, tie-break key, member sources
    typedef struct packed {
        logic [ACCW-1:0] mag;
        logic [IDXW-1:0] key;
        logic [NSRC-1:0] mask;
    } elem_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SORT,
        ST_PAIR,
        ST_DONE
    } state_e;

    // True when a belongs after b in ascending order
    function automatic logic elem_after(elem_t a, elem_t b);
        return (a.mag > b.mag) || ((a.mag == b.mag) && (a.key > b.key));
    endfunction

    function automatic elem_t elem_merge(elem_t a, elem_t b);
        elem_t r;
        r.mag  = a.mag + b.mag;
        r.key  = (a.key < b.key) ? a.key : b.key;
        r.mask = a.mask | b.mask;
        return r;
    endfunction

endpackage

// File: rtl/cf_sort_stage.sv
module cf_sort_stage
    import cf_pkg::*;
(
    input  elem_t           slots_i [NSRC],
    input  logic            par_i,
    input  logic [IDXW-1:0] cnt_i,
    output elem_t           slots_o [NSRC]
);

    // One odd-even transposition phase over the live prefix
    always_comb begin
        slots_o = slots_i;
        for (int i = 0; i < NSRC - 1; i++) begin
            if ((i[0] == par_i) && (IDXW'(i + 1) < cnt_i) &&
                elem_after(slots_i[i], slots_i[i+1])) begin
                slots_o[i]   = slots_i[i+1];
                slots_o[i+1] = slots_i[i];
            end
        end
    end

endmodule

// File: rtl/cf_pair_stage.sv
module cf_pair_stage
    import cf_pkg::*;
(
    input  logic            active_i,
    input  elem_t           slots_i [NSRC],
    input  logic [IDXW-1:0] cnt_i,
    output elem_t           slots_o [NSRC],
    output logic [IDXW-1:0] cnt_o,
    output logic [NSRC-1:0] odd_mask_o
);

    logic [IDXW-1:0]  half;
    logic [NPAIR-1:0] carry;

    always_comb begin
        logic [IDXW-1:0] partner;
        logic [ACCW:0]   wide;
        half = (cnt_i - IDXW'(1)) >> 1;
        for (int j = 0; j < NSRC; j++) begin
            slots_o[j] = '0;
        end
        carry = '0;
        for (int j = 0; j < NPAIR; j++) begin
            partner = cnt_i - IDXW'(1) - IDXW'(j);
            wide    = '0;
            if (IDXW'(j) < half) begin
                wide       = {1'b0, slots_i[j].mag} + {1'b0, slots_i[partner].mag};
                slots_o[j] = elem_merge(slots_i[j], slots_i[partner]);
                carry[j]   = wide[ACCW];
            end
        end
        cnt_o      = half;
        odd_mask_o = slots_i[half].mask;
    end

    always_comb begin
        if (active_i) begin
            // R10
            no_carry_chk: assert (carry == '0);
        end
    end

endmodule

// File: rtl/cf_fold_sequencer.sv
module cf_fold_sequencer
    import cf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_en,
    input  logic [IDXW-1:0]       load_idx,
    input  logic [MAGW-1:0]       load_mag,
    input  logic                  start,
    output logic                  done,
    output logic [NSRC*CODEW-1:0] grp_code
);

    state_e           state_q;
    logic [IDXW-1:0]  phase_q;
    logic [CODEW-1:0] fold_q;
    logic [IDXW-1:0]  cnt_q;
    logic [MAGW-1:0]  bank_q  [NSRC];
    elem_t            slot_q  [NSRC];
    logic [CODEW-1:0] codes_q [NSRC];

    elem_t            sorted   [NSRC];
    elem_t            paired   [NSRC];
    logic [IDXW-1:0]  pair_cnt;
    logic [NSRC-1:0]  odd_mask;
    logic             busy;
    logic             last_fold;

    assign busy      = (state_q == ST_SORT) || (state_q == ST_PAIR);
    assign done      = (state_q == ST_DONE);
    assign last_fold = (fold_q == CODEW'(LASTFOLD));

    cf_sort_stage u_sort (
        .slots_i (slot_q),
        .par_i   (phase_q[0]),
        .cnt_i   (cnt_q),
        .slots_o (sorted)
    );

    cf_pair_stage u_pair (
        .active_i   (state_q == ST_PAIR),
        .slots_i    (slot_q),
        .cnt_i      (cnt_q),
        .slots_o    (paired),
        .cnt_o      (pair_cnt),
        .odd_mask_o (odd_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            fold_q  <= '0;
            cnt_q   <= IDXW'(NSRC);
            for (int s = 0; s < NSRC; s++) begin
                bank_q[s]  <= '0;
                slot_q[s]  <= '0;
                codes_q[s] <= '0;
            end
        end else begin
            if (load_en && (load_idx < IDXW'(NSRC))) begin
                bank_q[load_idx] <= load_mag;
            end
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        for (int s = 0; s < NSRC; s++) begin
                            slot_q[s].mag  <= ACCW'(bank_q[s]);
                            slot_q[s].key  <= IDXW'(s);
                            slot_q[s].mask <= NSRC'(1) << s;
                        end
                        cnt_q   <= IDXW'(NSRC);
                        phase_q <= '0;
                        fold_q  <= '0;
                        state_q <= ST_SORT;
                    end
                end
                ST_SORT: begin
                    slot_q  <= sorted;
                    phase_q <= phase_q + IDXW'(1);
                    if (phase_q == IDXW'(NSRC - 1)) begin
                        state_q <= ST_PAIR;
                    end
                end
                ST_PAIR: begin
                    slot_q <= paired;
                    cnt_q  <= pair_cnt;
                    for (int s = 0; s < NSRC; s++) begin
                        if (odd_mask[s]) begin
                            codes_q[s] <= fold_q;
                        end else if (last_fold && paired[0].mask[s]) begin
                            codes_q[s] <= CODEW'(NBITS - 1);
                        end
                    end
                    if (last_fold) begin
                        state_q <= ST_DONE;
                    end else begin
                        fold_q  <= fold_q + CODEW'(1);
                        phase_q <= '0;
                        state_q <= ST_SORT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_out
        assign grp_code[s*CODEW +: CODEW] = codes_q[s];
    end

    // ---------------- assertions ----------------

    for (genvar i = 0; i < NSRC - 1; i++) begin : g_order
        // R3
        sorted_order_chk: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_PAIR && IDXW'(i + 1) < cnt_q) |->
                !elem_after(slot_q[i], slot_q[i+1]));
    end

    logic [IDXW:0] grp_cnt [NBITS];
    always_comb begin
        for (int k = 0; k < NBITS; k++) begin
            grp_cnt[k] = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (codes_q[s] == CODEW'(k)) begin
                    grp_cnt[k] = grp_cnt[k] + (IDXW+1)'(1);
                end
            end
        end
    end

    for (genvar k = 0; k < NBITS; k++) begin : g_grp
        // R7
        group_size_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(done) |-> grp_cnt[k] == (IDXW+1)'(1 << k));
    end

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state_q) == ST_PAIR) && ($past(fold_q) == CODEW'(LASTFOLD)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SORT && start) |=> phase_q == $past(phase_q) + IDXW'(1));

endmodule

// File: tb/test_cf_fold_sequencer.sv
module test_cf_fold_sequencer;
    import cf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = (NSRC + 1) * (NBITS - 1);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  load_en = 1'b0;
    logic [IDXW-1:0]       load_idx = '0;
    logic [MAGW-1:0]       load_mag = '0;
    logic                  start = 1'b0;
    logic                  done;
    logic [NSRC*CODEW-1:0] grp_code;

    int checks = 0;
    int errors = 0;
    int bank_m [NSRC];
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    cf_fold_sequencer i_cf_fold_sequencer (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_idx (load_idx),
        .load_mag (load_mag),
        .start    (start),
        .done     (done),
        .grp_code (grp_code)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(int s);
        return int'(grp_code[s*CODEW +: CODEW]);
    endfunction

    // Behavioural folding model: sort, join extremes, freeze the middle
    task automatic model(input int mg_in [NSRC], output int code [NSRC]);
        int mg [NSRC];
        int ky [NSRC];
        bit [NSRC-1:0] mk [NSRC];
        int m;
        int half;
        for (int s = 0; s < NSRC; s++) begin
            mg[s] = mg_in[s];
            ky[s] = s;
            mk[s] = '0;
            mk[s][s] = 1'b1;
            code[s] = -1;
        end
        m = NSRC;
        for (int f = 0; f <= LASTFOLD; f++) begin
            for (int a = 0; a < m; a++) begin
                for (int b = 0; b < m - 1 - a; b++) begin
                    if (mg[b] > mg[b+1] || (mg[b] == mg[b+1] && ky[b] > ky[b+1])) begin
                        int tm;
                        int tk;
                        bit [NSRC-1:0] tx;
                        tm = mg[b]; mg[b] = mg[b+1]; mg[b+1] = tm;
                        tk = ky[b]; ky[b] = ky[b+1]; ky[b+1] = tk;
                        tx = mk[b]; mk[b] = mk[b+1]; mk[b+1] = tx;
                    end
                end
            end
            half = (m - 1) / 2;
            for (int s = 0; s < NSRC; s++) begin
                if (mk[half][s]) code[s] = f;
            end
            for (int j = 0; j < half; j++) begin
                mg[j] = mg[j] + mg[m-1-j];
                ky[j] = (ky[j] < ky[m-1-j]) ? ky[j] : ky[m-1-j];
                mk[j] = mk[j] | mk[m-1-j];
            end
            m = half;
        end
        for (int s = 0; s < NSRC; s++) begin
            if (mk[0][s]) code[s] = NBITS - 1;
        end
    endtask

    task automatic load_one(int idx, int v);
        @(negedge clk);
        load_en  = 1'b1;
        load_idx = IDXW'(idx);
        load_mag = MAGW'(v);
        @(negedge clk);
        load_en  = 1'b0;
        if (idx < NSRC) bank_m[idx] = v;
    endtask

    // disturb >= 0: pulse start and write entry 3 in the middle of the run
    task automatic do_run(string tag, int disturb);
        int exp_code [NSRC];
        int cnt [NBITS];
        int snap [NSRC];
        for (int s = 0; s < NSRC; s++) snap[s] = bank_m[s];
        model(snap, exp_code);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            // R8: done low until the 48th edge after the accepting edge
            chk(done == 1'b0, "R8", {tag, " done early"}, int'(done), 0);
            if (k == disturb) begin
                start    = 1'b1;   // R9: ignored while busy
                load_en  = 1'b1;   // R2: bank write does not touch this run
                load_idx = IDXW'(3);
                load_mag = MAGW'(12'hABC);
                bank_m[3] = 12'hABC;
            end else begin
                start   = 1'b0;
                load_en = 1'b0;
            end
            @(negedge clk);
        end
        start   = 1'b0;
        load_en = 1'b0;
        chk(done == 1'b1, "R8", {tag, " done at latency"}, int'(done), 1);
        for (int s = 0; s < NSRC; s++) begin
            // R3 R4 shape the grouping; R5 frozen middles, R6 final group
            chk(code_of(s) == exp_code[s], (exp_code[s] == NBITS - 1) ? "R6" : "R5",
                $sformatf("%s code of source %0d", tag, s), code_of(s), exp_code[s]);
        end
        for (int k = 0; k < NBITS; k++) cnt[k] = 0;
        for (int s = 0; s < NSRC; s++) cnt[code_of(s)]++;
        for (int k = 0; k < NBITS; k++) begin
            chk(cnt[k] == (1 << k), "R7", $sformatf("%s size of group %0d", tag, k),
                cnt[k], 1 << k);
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R8", {tag, " done held"}, int'(done), 1);
        for (int s = 0; s < NSRC; s++) begin
            chk(code_of(s) == exp_code[s], "R8",
                $sformatf("%s held code of source %0d", tag, s), code_of(s), exp_code[s]);
        end
    endtask

    task automatic finish_report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_report();
    end

    initial begin
        for (int s = 0; s < NSRC; s++) bank_m[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(grp_code == '0, "R1", "table after reset", int'(grp_code), 0);

        // Ascending spread (R3, R4)
        for (int s = 0; s < NSRC; s++) load_one(s, 1000 + s * 37);
        do_run("ascending", -1);

        // Descending spread
        for (int s = 0; s < NSRC; s++) load_one(s, 3000 - s * 53);
        do_run("descending", -1);

        // All equal: ties settled by lowest source index (R3)
        for (int s = 0; s < NSRC; s++) load_one(s, 2048);
        do_run("ties", -1);

        // All at maximum: full-width sums (R10)
        for (int s = 0; s < NSRC; s++) load_one(s, 4095);
        do_run("maxval", -1);

        // Pseudo-random mismatch patterns
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < NSRC; s++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                load_one(s, 1900 + int'((seed >> 16) % 300));
            end
            do_run($sformatf("random%0d", r), -1);
        end

        // Out-of-range index writes nothing (R2); run result must match the bank
        load_one(15, 7);
        load_one(7, 1);
        do_run("idx15", -1);

        // Start and bank write during a run (R9, R2), then the new bank is used
        do_run("busy", 10);
        do_run("after_busy", -1);

        finish_report();
    end

endmodule